// File: doc/BRIEF.md
# Single-wire memory transaction sequencer

This block is the host-side controller that runs complete transactions against a single-wire serial memory target. The target has no reset pulse. Each transaction therefore opens with a long run of write-zero slots that pushes the target's address pointer to its locked top value. An 8-bit command follows, and its operation field sets the direction. Then exactly 256 data slots move the memory contents, least significant bit first. The sequencer does not time slots itself. It asks an external slot generator for one slot at a time, naming the slot kind, and waits for that generator's completion pulse before it moves on.

A client starts a transaction by raising `req_valid` while the block is idle. With the request it gives the direction and, for a write, a 256-bit data word. The word is captured when the request is accepted, so the client may change it afterwards. A read returns its 256 bits in `rd_data`, and `txn_done` pulses once the last data slot has finished. Once a transaction has started it cannot be aborted or redirected. Requests that arrive while the block is busy are dropped.

The controller has five states. IDLE goes to INIT when a request is accepted. INIT goes to CMD when the 264th write-zero slot completes. CMD goes to DATA when the 8th command slot completes. DATA goes to DONE when the 256th data slot completes. DONE always goes back to IDLE on the next cycle. A single 9-bit counter is cleared at every phase change and holds the slot index within the current phase.

Top module: `sw_txn_sequencer`

## Requirements
- R1: After reset, `busy`, `slot_req` and `txn_done` are low and `rd_data` is all zeros.
- R2: When `req_valid` is high and `busy` is low at a clock edge, `busy` is high from the next cycle. While `busy` is high, `req_valid`, `req_write` and `req_wdata` have no effect on the slots issued or on the data returned.
- R3: Slot kinds are encoded on `slot_kind` as 00 write-zero, 01 write-one and 10 read. The first 264 slots of every transaction are write-zero.
- R4: The next 8 slots send the command byte least significant bit first. Bit 0 is 1 and bits 1 and 2 are 0. Bits 3 to 7 are all 1 for a write (byte 0xF9) and all 0 for a read (byte 0x01). A 1 bit is a write-one slot and a 0 bit is a write-zero slot.
- R5: In a write, the 256 data slots follow the command. Data slot j is write-one if bit j of the data word captured at acceptance is 1, and write-zero otherwise.
- R6: In a read, the 256 data slots are read slots. The value of `slot_rbit` at the completion of data slot j is stored in `rd_data[j]`. `rd_data` is not changed by a write transaction or by an idle period.
- R7: `slot_req` stays high with a stable `slot_kind` until `slot_done` is seen. Each `slot_done` seen with `slot_req` high advances exactly one slot. A `slot_done` seen with `slot_req` low is ignored.
- R8: `txn_done` is high for exactly one cycle, the cycle after the final data slot completes. `slot_req` is low in that cycle, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transaction request, taken only when idle |
| req_write | input | 1 | 1 = write transaction, 0 = read |
| req_wdata | input | 256 | Data to write, bit 0 sent first |
| busy | output | 1 | A transaction is in progress |
| txn_done | output | 1 | One-cycle pulse at the end of a transaction |
| rd_data | output | 256 | Data returned by the most recent read |
| slot_req | output | 1 | Slot generator request, held until done |
| slot_kind | output | 2 | 00 write-zero, 01 write-one, 10 read |
| slot_done | input | 1 | Slot generator has completed the requested slot |
| slot_rbit | input | 1 | Bit sampled by a read slot, valid with slot_done |

## Verification
The bench acts as the slot generator. It stalls each slot for zero, one or two extra cycles, so a design that advanced without waiting for `slot_done` would fall out of step with the expected kind sequence. The bench also covers the phase boundaries at slots 264, 272 and 527. An off-by-one in any phase length would shift the command byte or drop the last data bit. The bench pokes `req_valid` with the opposite direction in the middle of a write and changes `req_wdata` after acceptance, so a design that reloaded either would emit wrong data slots. It also drives changing `slot_rbit` during write transactions and a stray `slot_done` while idle, so a design that captured read data outside read data slots would corrupt `rd_data`.

// File: rtl/swseq_pkg.sv
package swseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_INIT = 3'd1,
        ST_CMD  = 3'd2,
        ST_DATA = 3'd3,
        ST_DONE = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        SLOT_WR0 = 2'b00,
        SLOT_WR1 = 2'b01,
        SLOT_RD  = 2'b10
    } slot_kind_t;

    localparam int unsigned CMD_LEN    = 8;
    localparam int unsigned CMD_IDX_W  = 3;
    localparam int unsigned OPF_LEN    = 5;
    localparam int unsigned SEL_LEN    = 2;

    // Command byte, bit 0 sent first: start flag, target select, operation field
    function automatic logic [CMD_LEN-1:0] make_cmd(input logic is_write);
        logic [OPF_LEN-1:0] opf;
        opf = is_write ? {OPF_LEN{1'b1}} : {OPF_LEN{1'b0}};
        return {opf, {SEL_LEN{1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/swseq_phase_cnt.sv
module swseq_phase_cnt #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    // R7
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (cnt_q != '0));

endmodule

// File: rtl/swseq_cmd_gen.sv
module swseq_cmd_gen
    import swseq_pkg::*;
(
    input  logic                 is_write,
    input  logic [CMD_IDX_W-1:0] idx,
    output logic                 cmd_bit
);

    logic [CMD_LEN-1:0] cmd_byte;

    always_comb begin
        cmd_byte = make_cmd(is_write);
        cmd_bit  = cmd_byte[idx];
    end

endmodule

// File: rtl/swseq_rd_capture.sv
module swseq_rd_capture #(
    parameter int unsigned DW = 256,
    parameter int unsigned IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic [IW-1:0] idx,
    input  logic          bit_in,
    output logic [DW-1:0] rd_q
);

    for (genvar b = 0; b < DW; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q[b] <= 1'b0;
            end else if (wen && (idx == IW'(b))) begin
                rd_q[b] <= bit_in;
            end
        end
    end

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wen |=> $stable(rd_q));

endmodule

// File: rtl/sw_txn_sequencer.sv
module sw_txn_sequencer
    import swseq_pkg::*;
#(
    parameter int unsigned INIT_SLOTS = 264,
    parameter int unsigned DATA_SLOTS = 256,
    parameter int unsigned CNT_W      = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [DATA_SLOTS-1:0] req_wdata,
    output logic                  busy,
    output logic                  txn_done,
    output logic [DATA_SLOTS-1:0] rd_data,
    output logic                  slot_req,
    output logic [1:0]            slot_kind,
    input  logic                  slot_done,
    input  logic                  slot_rbit
);

    localparam int unsigned DIDX_W   = $clog2(DATA_SLOTS);
    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_SLOTS - 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_LEN - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_SLOTS - 1);

    seq_state_t            state_q, state_d;
    logic [CNT_W-1:0]      cnt;
    logic                  accept;
    logic                  slot_fire;
    logic                  phase_last;
    logic                  cnt_clr;
    logic                  cnt_inc;
    logic                  dir_wr_q;
    logic [DATA_SLOTS-1:0] wbuf_q;
    logic                  cmd_bit;
    logic                  rd_wen;
    slot_kind_t            kind;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign slot_fire = slot_req && slot_done;

    // Last slot of the current phase
    always_comb begin
        unique case (state_q)
            ST_INIT: phase_last = (cnt == INIT_LAST);
            ST_CMD:  phase_last = (cnt == CMD_LAST);
            ST_DATA: phase_last = (cnt == DATA_LAST);
            default: phase_last = 1'b0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)                   state_d = ST_INIT;
            ST_INIT: if (slot_fire && phase_last)  state_d = ST_CMD;
            ST_CMD:  if (slot_fire && phase_last)  state_d = ST_DATA;
            ST_DATA: if (slot_fire && phase_last)  state_d = ST_DONE;
            ST_DONE:                               state_d = ST_IDLE;
            default:                               state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_wr_q <= 1'b0;
            wbuf_q   <= '0;
        end else if (accept) begin
            dir_wr_q <= req_write;
            wbuf_q   <= req_wdata;
        end
    end

    assign cnt_clr = accept || (slot_fire && phase_last);
    assign cnt_inc = slot_fire && !phase_last;

    swseq_phase_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    swseq_cmd_gen u_cmd (
        .is_write (dir_wr_q),
        .idx      (cnt[CMD_IDX_W-1:0]),
        .cmd_bit  (cmd_bit)
    );

    assign rd_wen = slot_fire && (state_q == ST_DATA) && !dir_wr_q;

    swseq_rd_capture #(
        .DW (DATA_SLOTS),
        .IW (DIDX_W)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .wen    (rd_wen),
        .idx    (cnt[DIDX_W-1:0]),
        .bit_in (slot_rbit),
        .rd_q   (rd_data)
    );

    // Outputs
    always_comb begin
        slot_req = 1'b0;
        kind     = SLOT_WR0;
        busy     = 1'b1;
        txn_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_INIT: begin
                slot_req = 1'b1;
                kind     = SLOT_WR0;
            end
            ST_CMD: begin
                slot_req = 1'b1;
                kind     = cmd_bit ? SLOT_WR1 : SLOT_WR0;
            end
            ST_DATA: begin
                slot_req = 1'b1;
                if (dir_wr_q) begin
                    kind = wbuf_q[cnt[DIDX_W-1:0]] ? SLOT_WR1 : SLOT_WR0;
                end else begin
                    kind = SLOT_RD;
                end
            end
            ST_DONE: begin
                txn_done = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end

    assign slot_kind = kind;

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R3
    init_first_wr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (slot_req && (slot_kind == 2'b00)));

    // R7
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_done) |=> (slot_req && $stable(slot_kind)));

    // R8
    done_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |-> ($past(slot_done) && !slot_req));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |=> (!txn_done && !busy));

endmodule

// File: tb/sw_txn_sequencer_tb_top.sv
module sw_txn_sequencer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NINIT = 264;
    localparam int NCMD  = 8;
    localparam int NDATA = 256;
    localparam int NTOT  = NINIT + NCMD + NDATA;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [255:0] req_wdata = '0;
    logic         busy;
    logic         txn_done;
    logic [255:0] rd_data;
    logic         slot_req;
    logic [1:0]   slot_kind;
    logic         slot_done = 1'b0;
    logic         slot_rbit = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_txn_sequencer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .busy      (busy),
        .txn_done  (txn_done),
        .rd_data   (rd_data),
        .slot_req  (slot_req),
        .slot_kind (slot_kind),
        .slot_done (slot_done),
        .slot_rbit (slot_rbit)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected kind of slot i in a transaction, built from R3, R4, R5, R6
    function automatic logic [1:0] exp_kind(input int i, input bit wr, input logic [255:0] d);
        int c;
        if (i < NINIT) return 2'b00;
        if (i < NINIT + NCMD) begin
            c = i - NINIT;
            if (c == 0) return 2'b01;
            if (c >= 3 && wr) return 2'b01;
            return 2'b00;
        end
        if (wr) return d[i - NINIT - NCMD] ? 2'b01 : 2'b00;
        return 2'b10;
    endfunction

    function automatic string phase_tag(input int i, input bit wr);
        if (i < NINIT) return "R3 init slot";
        if (i < NINIT + NCMD) return "R4 command slot";
        return wr ? "R5 write data slot" : "R6 read data slot";
    endfunction

    task automatic run_txn(input bit wr, input logic [255:0] data,
                           input logic [255:0] pattern, input bit poke);
        logic [255:0] rd_before;
        logic [1:0]   ek;
        rd_before = rd_data;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = !wr;
        req_wdata = ~data;
        check("R2 busy after accept", {255'd0, busy}, 256'd1);
        for (int i = 0; i < NTOT; i++) begin
            ek = exp_kind(i, wr, data);
            check({phase_tag(i, wr), " req"}, {255'd0, slot_req}, 256'd1);
            check({phase_tag(i, wr), " kind"}, {254'd0, slot_kind}, {254'd0, ek});
            for (int d = 0; d < (i % 3); d++) begin
                if (poke && i == 301 && d == 0) begin
                    req_valid = 1'b1;
                end
                @(negedge clk);
                req_valid = 1'b0;
                check("R7 held req", {255'd0, slot_req}, 256'd1);
                check("R7 held kind", {254'd0, slot_kind}, {254'd0, ek});
            end
            slot_done = 1'b1;
            slot_rbit = (i >= NINIT + NCMD) ? pattern[i - NINIT - NCMD] : i[0];
            @(negedge clk);
            slot_done = 1'b0;
            slot_rbit = 1'b0;
        end
        check("R8 done pulse", {255'd0, txn_done}, 256'd1);
        check("R8 no req in done", {255'd0, slot_req}, 256'd0);
        @(negedge clk);
        check("R8 done single", {255'd0, txn_done}, 256'd0);
        check("R8 idle after done", {255'd0, busy}, 256'd0);
        check("R6 rd_data", rd_data, wr ? rd_before : pattern);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [255:0] pa, pb, pc;
        pa = {8{32'hA5C3_0F71}};
        pb = {16{16'h9E37}} ^ {256'd1 << 255} ^ 256'd1;
        pc = {4{64'h0123_4567_89AB_CDEF}};
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", {255'd0, busy}, 256'd0);
        check("R1 slot_req", {255'd0, slot_req}, 256'd0);
        check("R1 txn_done", {255'd0, txn_done}, 256'd0);
        check("R1 rd_data", rd_data, 256'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 stray done while idle ignored
        slot_done = 1'b1;
        slot_rbit = 1'b1;
        @(negedge clk);
        slot_done = 1'b0;
        slot_rbit = 1'b0;
        @(negedge clk);
        check("R7 stray done busy", {255'd0, busy}, 256'd0);
        check("R7 stray done req", {255'd0, slot_req}, 256'd0);
        check("R7 stray done rd", rd_data, 256'd0);
        run_txn(1'b0, 256'd0, pa, 1'b0);
        run_txn(1'b1, pb, ~pa, 1'b1);
        run_txn(1'b0, pb, pc, 1'b1);
        run_txn(1'b1, {256{1'b1}}, 256'd0, 1'b0);
        run_txn(1'b0, 256'd0, 256'd1 << 255, 1'b0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule